// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 10-bit successive-approximation converter that sits on a processor bus. The processor starts a conversion by pulling chip select and write low together. While both strobes stay low, the sequencer holds its search logic cleared. Once either strobe returns high, the search starts on the next boundary of a free-running clock divider. The search tests one bit per divider slot, most significant bit first. It drives a tap-select code to the external resistor/capacitor network and reads back a one-bit comparator decision.

When the last bit is resolved, the finished word is copied into an output latch. A short set pulse then raises the interrupt flip-flop, and the interrupt output is active low. Pulling chip select and read low together puts the latch on the data bus and clears the interrupt. The set pulse takes priority over that clear, so the end of a conversion is still signalled when the bus is read continuously.

A new start request during a search abandons that search and starts a new one. If the interrupt output is wired back to the write strobe and chip select is held low, the block converts continuously.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, tap_code is 0, intr_n is 1 and data_oe is 0. No search begins until a start request (cs_n=0 and wr_n=0 in the same cycle) is seen.
- R2: While cs_n and wr_n are both low, tap_code is 0 from the following clock on. The interrupt flip-flop is cleared except while a set pulse is active.
- R3: After the start request is released, the first step loads tap_code with only bit NBITS-1 set. This happens 1 to SLOT_CLKS clocks after the release, on the divider boundary.
- R4: Bits are resolved from MSB to LSB, one every SLOT_CLKS clocks. intr_n falls exactly NBITS*SLOT_CLKS+1 clocks after the first trial code appears (81 clocks with the defaults).
- R5: At the end of each slot, the bit under test is kept if cmp_ge=1 and cleared if cmp_ge=0. The latched result is the straight-binary code, and all ones is full scale.
- R6: data_oe is 1 exactly when cs_n=0 and rd_n=0. data_out then carries the latched result. At all other times data_out is all zeros.
- R7: intr_n goes low after the transfer and stays low until a read or a new start request.
- R8: A read (cs_n=0, rd_n=0) clears the interrupt. A read held continuously still lets intr_n go low for exactly PULSE_CLKS clocks at each transfer.
- R9: A start request during a search aborts it. The following search runs from the MSB, and its result replaces the latch contents.
- R10: With cs_n held low and wr_n driven from intr_n, conversions repeat with no further stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write/start strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cmp_ge | input | 1 | Comparator decision: 1 when the input is at or above the current tap |
| tap_code | output | NBITS | Trial code driving the ladder network |
| data_out | output | NBITS | Latched result, zero when not enabled |
| data_oe | output | 1 | Data bus drive enable |
| intr_n | output | 1 | End-of-conversion interrupt, active low |

## Verification
The bench uses the default NBITS of 10 and SLOT_CLKS of 8, so the 81-clock span from the first trial to the interrupt is checked at its full length. PULSE_CLKS is set to 3 instead of 1. With a three-clock set pulse, a held read shows a measurable interrupt width, and a one-clock error in that width cannot go unnoticed. The comparator model follows a bench-side input code, so inputs of 0, 1023 and mid-scale exercise both the all-cleared and all-kept paths.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int unsigned DEF_NBITS = 10;
    localparam int unsigned DEF_SLOT  = 8;
    localparam int unsigned DEF_PULSE = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
    parameter int unsigned SLOT_CLKS = sar_pkg::DEF_SLOT
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        tick  = (div_q.cnt == CW'(SLOT_CLKS - 1));
        if (tick) div_d.cnt = '0;
        else      div_d.cnt = div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/sar_start_ctrl.sv
module sar_start_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic tick,
    input  logic xfer,
    output logic hold,
    output logic launch
);
    import sar_pkg::*;

    typedef struct packed {
        seq_state_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d  = ctl_q;
        hold   = (ctl_q.st == SEQ_HOLD);
        launch = hold && tick && !start_req;
        if (start_req)                        ctl_d.st = SEQ_HOLD;
        else if (launch)                      ctl_d.st = SEQ_RUN;
        else if (ctl_q.st == SEQ_RUN && xfer) ctl_d.st = SEQ_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: SEQ_IDLE};
        else        ctl_q <= ctl_d;
    end

    // R3
    launch_leaves_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (ctl_q.st == SEQ_RUN));
endmodule

// File: rtl/sar_search.sv
module sar_search #(
    parameter int unsigned NBITS = sar_pkg::DEF_NBITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             launch,
    input  logic             tick,
    input  logic             cmp_ge,
    output logic [NBITS-1:0] tap_code,
    output logic [NBITS-1:0] result,
    output logic             xfer
);
    localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

    typedef struct packed {
        logic [NBITS-1:0] walk;
        logic [NBITS-1:0] sar;
        logic [NBITS-1:0] latch;
    } srch_t;

    srch_t s_d, s_q;
    logic [NBITS-1:0] resolved;

    always_comb begin
        s_d      = s_q;
        xfer     = 1'b0;
        resolved = cmp_ge ? s_q.sar : (s_q.sar & ~s_q.walk);
        if (launch) begin
            s_d.walk = TOP_BIT;
            s_d.sar  = TOP_BIT;
        end else if (clear) begin
            s_d.walk = '0;
            s_d.sar  = '0;
        end else if (tick && (|s_q.walk)) begin
            s_d.walk = s_q.walk >> 1;
            s_d.sar  = resolved | (s_q.walk >> 1);
            if (s_q.walk[0]) begin
                s_d.latch = resolved;
                xfer      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tap_code = s_q.sar;
    assign result   = s_q.latch;

    // R4
    walk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.walk));

    // R5
    latch_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.latch) |-> $past(s_q.walk[0] && tick));
endmodule

// File: rtl/sar_irq.sv
module sar_irq #(
    parameter int unsigned PULSE_CLKS = sar_pkg::DEF_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer,
    input  logic clr,
    output logic intr_n
);
    localparam int unsigned PW = $clog2(PULSE_CLKS + 1);

    typedef struct packed {
        logic [PW-1:0] pulse;
        logic          flag;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (xfer)                 i_d.pulse = PW'(PULSE_CLKS);
        else if (i_q.pulse != '0) i_d.pulse = i_q.pulse - 1'b1;
        if (i_q.pulse != '0) i_d.flag = 1'b1;
        else if (clr)        i_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign intr_n = ~i_q.flag;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_q.pulse != '0) |=> i_q.flag);
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
    parameter int unsigned NBITS      = sar_pkg::DEF_NBITS,
    parameter int unsigned SLOT_CLKS  = sar_pkg::DEF_SLOT,
    parameter int unsigned PULSE_CLKS = sar_pkg::DEF_PULSE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cmp_ge,
    output logic [NBITS-1:0] tap_code,
    output logic [NBITS-1:0] data_out,
    output logic             data_oe,
    output logic             intr_n
);
    logic start_req, rd_sel, tick, hold, launch, xfer;
    logic [NBITS-1:0] result;

    assign start_req = !cs_n && !wr_n;
    assign rd_sel    = !cs_n && !rd_n;

    sar_prescaler #(.SLOT_CLKS(SLOT_CLKS)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    sar_start_ctrl u_start (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .tick(tick),
        .xfer(xfer), .hold(hold), .launch(launch)
    );

    sar_search #(.NBITS(NBITS)) u_search (
        .clk(clk), .rst_n(rst_n), .clear(start_req || hold), .launch(launch),
        .tick(tick), .cmp_ge(cmp_ge), .tap_code(tap_code), .result(result),
        .xfer(xfer)
    );

    sar_irq #(.PULSE_CLKS(PULSE_CLKS)) u_irq (
        .clk(clk), .rst_n(rst_n), .xfer(xfer), .clr(rd_sel || hold),
        .intr_n(intr_n)
    );

    assign data_oe  = rd_sel;
    assign data_out = rd_sel ? result : '0;

    // R2
    hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> (tap_code == '0));

    // R3
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tap_code != '0) && ($past(tap_code) == '0)) |-> $past(tick));
endmodule

// File: tb/sar_seq_top_bench.sv
module sar_seq_top_bench;
    localparam int NB = 10;
    localparam int SL = 8;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    int   vin = 0;
    logic cmp_ge;
    logic [NB-1:0] tap_code, data_out;
    logic data_oe, intr_n;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign cmp_ge = (vin >= int'(tap_code));

    sar_seq_top #(.NBITS(NB), .SLOT_CLKS(SL), .PULSE_CLKS(PW)) u_sar_seq_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cmp_ge(cmp_ge), .tap_code(tap_code), .data_out(data_out),
        .data_oe(data_oe), .intr_n(intr_n)
    );

    // behavioural reference
    int m_div = 0, m_bit = -1, m_trial = 0, m_latch = 0, m_pulse = 0;
    bit m_start = 0, m_irq = 0;

    always @(posedge clk) begin
        bit req, rdq, tk, nirq;
        int npulse;
        if (!rst_n) begin
            m_div = 0; m_bit = -1; m_trial = 0; m_latch = 0;
            m_pulse = 0; m_start = 0; m_irq = 0;
        end else begin
            req = !cs_n && !wr_n;
            rdq = !cs_n && !rd_n;
            tk  = (m_div == SL - 1);
            nirq = (m_pulse > 0) ? 1'b1 : ((rdq || m_start) ? 1'b0 : m_irq);
            npulse = (m_pulse > 0) ? m_pulse - 1 : 0;
            if (req) begin
                m_start = 1; m_bit = -1; m_trial = 0;
            end else if (m_start && tk) begin
                m_start = 0; m_bit = NB - 1; m_trial = 1 << (NB - 1);
            end else if (m_bit >= 0 && tk) begin
                if (vin < m_trial) m_trial -= (1 << m_bit);
                if (m_bit == 0) begin
                    m_latch = m_trial; npulse = PW; m_bit = -1;
                end else begin
                    m_bit--; m_trial += (1 << m_bit);
                end
            end
            m_irq = nirq; m_pulse = npulse;
            m_div = (m_div + 1) % SL;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            bit rdq;
            rdq = !cs_n && !rd_n;
            check(int'(tap_code) == m_trial, "R4 tap_code", int'(tap_code), m_trial);
            check(intr_n == !m_irq, "R7 intr_n", intr_n, !m_irq);
            check(data_oe == rdq, "R6 data_oe", data_oe, rdq);
            check(int'(data_out) == (rdq ? m_latch : 0), "R6 data_out",
                  int'(data_out), rdq ? m_latch : 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic start_conv(output int lat);
        cs_n = 0; wr_n = 0; step(2);
        cs_n = 1; wr_n = 1;
        lat = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (tap_code != 0) begin lat = i; break; end
        end
    endtask

    task automatic wait_intr(output int n);
        n = -1;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (intr_n == 1'b0) begin n = i; break; end
        end
        step(1);
    endtask

    task automatic do_read(output int val);
        cs_n = 0; rd_n = 0; step(1);
        @(negedge clk); val = int'(data_out);
        step(1);
        cs_n = 1; rd_n = 1; step(1);
    endtask

    task automatic full_conv(input int v, input string tag);
        int lat, n, val;
        vin = v;
        start_conv(lat);
        wait_intr(n);
        do_read(val);
        check(val == v, tag, val, v);
    endtask

    initial begin
        int lat, n, val, falls, lowlen;
        bit prev;
        step(2);
        @(negedge clk);
        // R1 reset state
        check(tap_code == 0 && intr_n == 1 && data_oe == 0, "R1 reset", int'(tap_code), 0);
        step(1);
        rst_n = 1;
        step(40);
        @(negedge clk);
        check(tap_code == 0 && intr_n == 1, "R1 idle until start", int'(tap_code), 0);

        // R3/R4/R5 basic conversion
        vin = 341;
        start_conv(lat);
        check(lat >= 1 && lat <= SL, "R3 start latency", lat, SL);
        check(int'(tap_code) == 512, "R3 first trial", int'(tap_code), 512);
        wait_intr(n);
        check(n == NB * SL + 1, "R4 conversion span", n, NB * SL + 1);
        step(4);
        @(negedge clk);
        check(intr_n == 0, "R7 intr held", intr_n, 0);
        do_read(val);
        check(val == 341, "R5 result 341", val, 341);
        @(negedge clk);
        check(intr_n == 1, "R8 read clears intr", intr_n, 1);

        // R6 not selected
        cs_n = 1; rd_n = 0; step(1);
        @(negedge clk);
        check(data_oe == 0 && data_out == 0, "R6 bus idle", int'(data_out), 0);
        rd_n = 1; step(1);

        // R5 boundaries
        full_conv(0, "R5 zero");
        full_conv(1023, "R5 full scale");
        full_conv(512, "R5 mid");

        // R2 long hold
        vin = 700;
        cs_n = 0; wr_n = 0; step(1);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tap_code != 0) begin
                check(0, "R2 hold", int'(tap_code), 0); break;
            end
        end
        check(tap_code == 0, "R2 hold end", int'(tap_code), 0);
        step(1);
        cs_n = 1; wr_n = 1;
        wait_intr(n);
        do_read(val);
        check(val == 700, "R2 after hold", val, 700);

        // R9 abort
        vin = 100;
        start_conv(lat);
        step(30);
        vin = 900;
        start_conv(lat);
        check(int'(tap_code) == 512, "R9 restart from MSB", int'(tap_code), 512);
        wait_intr(n);
        check(n == NB * SL + 1, "R9 span", n, NB * SL + 1);
        do_read(val);
        check(val == 900, "R9 result", val, 900);

        // R8 continuous read
        vin = 77;
        cs_n = 0; rd_n = 0; wr_n = 0; step(2);
        wr_n = 1;
        lowlen = 0; prev = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (intr_n == 0) lowlen++;
            if (prev == 0 && intr_n == 1) break;
            prev = intr_n;
        end
        check(lowlen == PW, "R8 pulse width", lowlen, PW);
        check(int'(data_out) == 77, "R8 data under read", int'(data_out), 77);
        step(1);
        cs_n = 1; rd_n = 1; step(2);

        // R10 free-running
        vin = 250;
        cs_n = 0; wr_n = 0; step(2);
        falls = 0; prev = intr_n;
        for (int i = 0; i < 500; i++) begin
            wr_n = intr_n;
            @(negedge clk);
            if (prev == 1 && intr_n == 0) falls++;
            prev = intr_n;
            @(posedge clk); #2;
        end
        check(falls >= 3, "R10 repeated conversions", falls, 3);
        wr_n = 1; cs_n = 1; step(2);
        do_read(val);
        check(val == 250, "R10 result", val, 250);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule